// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port for a chip's pin ring. A test clock, a mode-select line and a serial data input steer a sixteen-state controller. The controller picks one register at a time and places it between the serial input and the serial output. The registers are a 3-bit instruction register, a 1-bit bypass register, a 32-bit identification register and a boundary chain. The boundary chain has one cell per functional pin, plus one extra cell that decides whether the output bus drives.

A tester loads an instruction and then scans data. It can read the identification code, snapshot the pins, preload a pattern, or drive that pattern onto the pads with the functional path switched off. The pad ring uses `ext_sel` to choose between core data and `pin_out`, and uses `func_oe` as the output-buffer enable. All control sits in the test-clock domain. State is initialised by an asynchronous power-on reset.

Top module: `tap_port`

## Requirements
- R1: The block samples TMS and TDI on the rising TCK edge and changes TDO only on the falling edge. `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR, and it is 0 after power-on reset.
- R2: Five consecutive rising edges with TMS high bring the controller to Test-Logic-Reset from any state.
- R3: The active instruction is 3 bits wide. It holds IDCODE (001) after power-on reset and after every pass through Test-Logic-Reset.
- R4: Capture-IR loads the instruction shift register with 001, so the first three bits scanned out are 1, 0, 0.
- R5: A selected register takes TDI into its MSB and presents its LSB on TDO. A shifted instruction has no effect on `func_oe` or `ext_sel` until the clock edge that leaves Update-IR.
- R6: BYPASS (111) and the unused codes 011, 101 and 110 select a 1-bit register that captures 0, giving a scan path of length 1.
- R7: IDCODE selects a 32-bit register. The register captures the `ID_VALUE` parameter in Capture-DR and shifts it out LSB first.
- R8: The boundary chain is NPIN+1 bits long. Bits NPIN-1..0 capture `pin_in` in Capture-DR. Bit NPIN is the output-enable cell and captures its own latched value. On the edge leaving Update-DR, the shifted bits NPIN-1..0 appear on `pin_out`. Before that edge, `pin_out` holds its old value.
- R9: SAMPLE Z (010) selects the boundary chain and forces `func_oe` to 0.
- R10: EXTEST (000) selects the boundary chain and sets `ext_sel` to 1. Under EXTEST, `func_oe` equals the latched output-enable cell. That cell is preset to 1 at power-on reset and in Test-Logic-Reset.
- R11: Under SAMPLE/PRELOAD (100), IDCODE, BYPASS and the unused codes, `func_oe` is 1 and `ext_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| pin_in | input | NPIN | Pin values captured into the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Enable for the TDO driver |
| pin_out | output | NPIN | Latched boundary pattern for the pads |
| func_oe | output | 1 | Output-buffer enable for the functional pins |
| ext_sel | output | 1 | Selects `pin_out` as the pad data source |

## Verification
TDO and `tdo_oe` are due at the falling edge that follows the rising edge that changed the state or shifted the register. The bench therefore drives TMS and TDI just after a falling edge and reads TDO shortly after the next falling edge. The first scanned bit is read as soon as a Shift state is entered, before any shift takes place.

An instruction shows on `func_oe` and `ext_sel` only after the rising edge that leaves Update-IR. `pin_out` changes only after the rising edge that leaves Update-DR. The bench checks both values one step before and one step after those edges.

The scan length of each instruction is measured by flushing the path with zeros, injecting a single one and counting the shifts until it appears on TDO.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHIFT_DR,
        ST_EXIT1_DR,
        ST_PAUSE_DR,
        ST_EXIT2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SHIFT_IR,
        ST_EXIT1_IR,
        ST_PAUSE_IR,
        ST_EXIT2_IR,
        ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYPASS,
        SEL_ID,
        SEL_BSR
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

    // Value placed in the instruction shifter on Capture-IR
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST, OP_SAMPLEZ, OP_PRELOAD: dr_decode = SEL_BSR;
            OP_IDCODE:                         dr_decode = SEL_ID;
            default:                           dr_decode = SEL_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state_q
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_RESET:    r_d.st = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     r_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   r_d.st = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   r_d.st = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: r_d.st = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: r_d.st = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: r_d.st = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: r_d.st = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   r_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   r_d.st = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   r_d.st = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: r_d.st = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: r_d.st = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: r_d.st = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: r_d.st = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   r_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            default:     r_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) r_q <= '{st: ST_RESET};
        else        r_q <= r_d;
    end

    assign state_q = r_q.st;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  tap_state_e      state_q,
    output logic [IR_W-1:0] ir_sh,
    output logic [IR_W-1:0] ir_act
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] act;
    } ir_t;

    ir_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state_q)
            ST_RESET:    r_d.act = OP_IDCODE;
            ST_CAP_IR:   r_d.sh  = IR_CAPTURE;
            ST_SHIFT_IR: r_d.sh  = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR:   r_d.act = r_q.sh;
            default:     ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) r_q <= '{sh: IR_CAPTURE, act: OP_IDCODE};
        else        r_q <= r_d;
    end

    assign ir_sh  = r_q.sh;
    assign ir_act = r_q.act;

endmodule

// File: rtl/tap_dr_fixed.sv
module tap_dr_fixed
    import tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E07
) (
    input  logic       tck,
    input  logic       por_n,
    input  logic       tdi,
    input  tap_state_e state_q,
    input  logic       sel_byp,
    input  logic       sel_id,
    output logic       byp_q,
    output logic       id_lsb
);

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } fix_t;

    fix_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state_q == ST_CAP_DR) begin
            if (sel_byp) r_d.byp = 1'b0;
            if (sel_id)  r_d.id  = ID_VALUE;
        end else if (state_q == ST_SHIFT_DR) begin
            if (sel_byp) r_d.byp = tdi;
            if (sel_id)  r_d.id  = {tdi, r_q.id[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) r_q <= '{byp: 1'b0, id: ID_VALUE};
        else        r_q <= r_d;
    end

    assign byp_q  = r_q.byp;
    assign id_lsb = r_q.id[0];

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
    import tap_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  tap_state_e      state_q,
    input  logic            sel,
    input  logic [NPIN-1:0] pin_in,
    output logic            bsr_lsb,
    output logic [NPIN-1:0] pin_upd,
    output logic            oe_cell
);

    localparam int CHAIN  = NPIN + 1;
    localparam int OE_POS = NPIN;
    localparam logic [CHAIN-1:0] UPD_INIT = {1'b1, {NPIN{1'b0}}};

    typedef struct packed {
        logic [CHAIN-1:0] sh;
        logic [CHAIN-1:0] upd;
    } bsr_t;

    bsr_t r_d, r_q;
    logic [CHAIN-1:0] shift_nx;

    // Each cell takes its upstream neighbour; the top cell takes TDI
    for (genvar g = 0; g < CHAIN; g++) begin : g_cell
        if (g == CHAIN - 1) begin : g_head
            assign shift_nx[g] = tdi;
        end else begin : g_body
            assign shift_nx[g] = r_q.sh[g+1];
        end
    end

    always_comb begin
        r_d = r_q;
        if (sel) begin
            case (state_q)
                ST_CAP_DR:   r_d.sh  = {r_q.upd[OE_POS], pin_in};
                ST_SHIFT_DR: r_d.sh  = shift_nx;
                ST_UPD_DR:   r_d.upd = r_q.sh;
                default:     ;
            endcase
        end
        if (state_q == ST_RESET) r_d.upd[OE_POS] = 1'b1;
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) r_q <= '{sh: '0, upd: UPD_INIT};
        else        r_q <= r_d;
    end

    assign bsr_lsb = r_q.sh[0];
    assign pin_upd = r_q.upd[NPIN-1:0];
    assign oe_cell = r_q.upd[OE_POS];

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter int              NPIN     = 8,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E07
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            tms,
    input  logic            tdi,
    input  logic [NPIN-1:0] pin_in,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [NPIN-1:0] pin_out,
    output logic            func_oe,
    output logic            ext_sel
);

    tap_state_e      state_q;
    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_act;
    dr_sel_e         dr_sel;
    logic            byp_q;
    logic            id_lsb;
    logic            bsr_lsb;
    logic            oe_cell;

    tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .tms     (tms),
        .state_q (state_q)
    );

    tap_ir u_ir (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .state_q (state_q),
        .ir_sh   (ir_sh),
        .ir_act  (ir_act)
    );

    assign dr_sel = dr_decode(ir_act);

    tap_dr_fixed #(.ID_VALUE(ID_VALUE)) u_fix (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .state_q (state_q),
        .sel_byp (dr_sel == SEL_BYPASS),
        .sel_id  (dr_sel == SEL_ID),
        .byp_q   (byp_q),
        .id_lsb  (id_lsb)
    );

    tap_bsr #(.NPIN(NPIN)) u_bsr (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .state_q (state_q),
        .sel     (dr_sel == SEL_BSR),
        .pin_in  (pin_in),
        .bsr_lsb (bsr_lsb),
        .pin_upd (pin_out),
        .oe_cell (oe_cell)
    );

    // Serial output stage, launched on the falling test-clock edge
    typedef struct packed {
        logic tdo;
        logic oe;
    } so_t;

    so_t s_d, s_q;

    always_comb begin
        s_d.oe = (state_q == ST_SHIFT_IR) || (state_q == ST_SHIFT_DR);
        if (state_q == ST_SHIFT_IR) begin
            s_d.tdo = ir_sh[0];
        end else begin
            case (dr_sel)
                SEL_ID:  s_d.tdo = id_lsb;
                SEL_BSR: s_d.tdo = bsr_lsb;
                default: s_d.tdo = byp_q;
            endcase
        end
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) s_q <= '{tdo: 1'b0, oe: 1'b0};
        else        s_q <= s_d;
    end

    assign tdo     = s_q.tdo;
    assign tdo_oe  = s_q.oe;
    assign ext_sel = (ir_act == OP_EXTEST);
    assign func_oe = (ir_act == OP_SAMPLEZ) ? 1'b0 :
                     (ir_act == OP_EXTEST)  ? oe_cell : 1'b1;

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            por_n,
    input logic            tms,
    input tap_state_e      state_q,
    input logic [IR_W-1:0] ir_act,
    input logic [IR_W-1:0] ir_sh,
    input dr_sel_e         dr_sel,
    input logic            byp_q,
    input logic            oe_cell,
    input logic            func_oe,
    input logic            tdo_oe
);

    logic [2:0] hi_cnt;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)        hi_cnt <= 3'd0;
        else if (!tms)     hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    a_r1_tdo_oe_in_shift: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe == ((state_q == ST_SHIFT_DR) || (state_q == ST_SHIFT_IR)));

    a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!por_n)
        (hi_cnt == 3'd5) |-> (state_q == ST_RESET));

    a_r3_reset_idcode: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == ST_RESET) |=> (ir_act == OP_IDCODE));

    a_r4_capture_ir: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == ST_CAP_IR) |=> (ir_sh == 3'b001));

    a_r5_ir_only_on_update: assert property (@(posedge tck) disable iff (!por_n)
        ((state_q != ST_UPD_IR) && (state_q != ST_RESET)) |=> $stable(ir_act));

    a_r6_bypass_captures_zero: assert property (@(posedge tck) disable iff (!por_n)
        ((state_q == ST_CAP_DR) && (dr_sel == SEL_BYPASS)) |=> !byp_q);

    a_r9_samplez_quiet: assert property (@(posedge tck) disable iff (!por_n)
        (ir_act == OP_SAMPLEZ) |-> !func_oe);

    a_r10_oe_cell_preset: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == ST_RESET) |=> oe_cell);

endmodule

bind tap_port tap_port_chk u_chk (
    .tck     (tck),
    .por_n   (por_n),
    .tms     (tms),
    .state_q (state_q),
    .ir_act  (ir_act),
    .ir_sh   (ir_sh),
    .dr_sel  (dr_sel),
    .byp_q   (byp_q),
    .oe_cell (oe_cell),
    .func_oe (func_oe),
    .tdo_oe  (tdo_oe)
);

// File: tb/tb_tap_port.sv
module tb_tap_port;

    localparam int          PERIOD = 20;
    localparam int          NPIN   = 8;
    localparam int          BLEN   = NPIN + 1;
    localparam logic [31:0] IDV    = 32'h1A5C_3E07;

    logic            tck = 1'b0;
    logic            por_n = 1'b0;
    logic            tms = 1'b1;
    logic            tdi = 1'b0;
    logic [NPIN-1:0] pin_in = '0;
    logic            tdo, tdo_oe, func_oe, ext_sel;
    logic [NPIN-1:0] pin_out;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) tck = ~tck;

    tap_port #(.NPIN(NPIN), .ID_VALUE(IDV)) dut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out),
        .func_oe(func_oe), .ext_sel(ext_sel)
    );

    typedef struct packed {
        logic [2:0] code;
        logic [6:0] len;
        logic       oe;
        logic       ext;
    } vec_t;

    // Per instruction: scan length, func_oe and ext_sel (R6, R9, R10, R11)
    localparam vec_t VEC [8] = '{
        '{3'b000, 7'(BLEN), 1'b1, 1'b1},
        '{3'b001, 7'd32,    1'b1, 1'b0},
        '{3'b010, 7'(BLEN), 1'b0, 1'b0},
        '{3'b011, 7'd1,     1'b1, 1'b0},
        '{3'b100, 7'(BLEN), 1'b1, 1'b0},
        '{3'b101, 7'd1,     1'b1, 1'b0},
        '{3'b110, 7'd1,     1'b1, 1'b0},
        '{3'b111, 7'd1,     1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic to_reset_idle();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [2:0] code);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, code[0]);
        step(1'b0, code[1]);
        step(1'b1, code[2]);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic to_shift_dr();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // Shift n bits, leaving the controller in Exit1-DR
    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step((i == n - 1), din[i]);
        end
    endtask

    task automatic measure_len(output int len);
        len = 0;
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
        for (int i = 0; i < 48; i++) begin
            if (len == 0) begin
                step(1'b0, (i == 0));
                if (tdo) len = i + 1;
            end
        end
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        #(PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] dout;
        int          len;

        #(PERIOD * 3);
        @(negedge tck);
        #1;
        // Reset state: R1, R3, R10, R11
        chk("R1 tdo_oe after power-on", 64'(tdo_oe), 64'd0);
        chk("R11 func_oe under IDCODE at power-on", 64'(func_oe), 64'd1);
        chk("R11 ext_sel at power-on", 64'(ext_sel), 64'd0);
        chk("R8 pin_out at power-on", 64'(pin_out), 64'd0);
        por_n = 1'b1;
        step(1'b1, 1'b0);

        // R7/R3: IDCODE active after power-on, scanned LSB first
        step(1'b0, 1'b0);
        to_shift_dr();
        chk("R1 tdo_oe in Shift-DR", 64'(tdo_oe), 64'd1);
        shift_dr(32, 64'd0, dout);
        chk("R7 identification value", dout, 64'(IDV));
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 tdo_oe in Run-Test/Idle", 64'(tdo_oe), 64'd0);

        // Vector table walk: every instruction code
        foreach (VEC[k]) begin
            load_ir(VEC[k].code);
            chk($sformatf("R11 R9 R10 func_oe code %0b", VEC[k].code), 64'(func_oe), 64'(VEC[k].oe));
            chk($sformatf("R10 R11 ext_sel code %0b", VEC[k].code), 64'(ext_sel), 64'(VEC[k].ext));
            to_shift_dr();
            measure_len(len);
            chk($sformatf("R6 R7 R8 scan length code %0b", VEC[k].code), 64'(len), 64'(VEC[k].len));
        end

        // R4 / R5: capture pattern and delayed instruction effect
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 tdo_oe in Shift-IR", 64'(tdo_oe), 64'd1);
        chk("R4 captured bit0", 64'(tdo), 64'd1);
        step(1'b0, 1'b0);
        chk("R4 captured bit1", 64'(tdo), 64'd0);
        step(1'b0, 1'b1);
        chk("R4 captured bit2", 64'(tdo), 64'd0);
        step(1'b1, 1'b0);
        chk("R5 func_oe unchanged before Update-IR", 64'(func_oe), 64'd1);
        step(1'b1, 1'b0);
        chk("R5 func_oe unchanged in Update-IR", 64'(func_oe), 64'd1);
        step(1'b0, 1'b0);
        chk("R9 SAMPLE Z drops func_oe", 64'(func_oe), 64'd0);

        // R2 / R3: leave Shift-DR under BYPASS by five TMS-high edges
        load_ir(3'b111);
        to_shift_dr();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk("R2 tdo_oe off after five TMS high", 64'(tdo_oe), 64'd0);
        step(1'b0, 1'b0);
        to_shift_dr();
        shift_dr(32, 64'd0, dout);
        chk("R2 R3 IDCODE restored by Test-Logic-Reset", dout, 64'(IDV));
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);

        // R8: SAMPLE/PRELOAD capture and update
        pin_in = 8'hA5;
        load_ir(3'b100);
        to_shift_dr();
        shift_dr(BLEN, 64'h03C, dout);
        chk("R8 captured pins with enable cell", dout, 64'h1A5);
        chk("R8 pin_out held before Update-DR", 64'(pin_out), 64'd0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R8 pin_out after Update-DR", 64'(pin_out), 64'h3C);
        chk("R11 func_oe under SAMPLE/PRELOAD", 64'(func_oe), 64'd1);

        // R10: EXTEST uses the latched enable cell, preset by reset state
        load_ir(3'b000);
        chk("R10 ext_sel under EXTEST", 64'(ext_sel), 64'd1);
        chk("R10 func_oe follows cleared enable cell", 64'(func_oe), 64'd0);
        chk("R10 pin_out kept", 64'(pin_out), 64'h3C);
        to_reset_idle();
        load_ir(3'b000);
        chk("R10 enable cell preset by Test-Logic-Reset", 64'(func_oe), 64'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule